// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is a down-counting watchdog for a processor subsystem. A prescaler divides the counter clock, and the main counter decrements once for each prescaler wrap. Software reaches the block through a simple register write/read port with four word addresses: key, control, reload and window. The key register is always writable, and the 16-bit value written to it acts as a command. One value opens the other registers for writing. A second value feeds the watchdog and locks the registers again. A third value starts the watchdog, and once started it cannot be stopped.

Software feeds the watchdog to show that it is still alive. A missed feed lets the counter reach zero, and the block then raises a reset request. A feed that comes too early, while the counter is still above the programmed window value, raises the same reset request. Before the timeout, an optional early interrupt can warn software. While the system sleeps, that interrupt is also presented as a wakeup request. Counting is held while any CPU is halted for debug or while no CPU is active. In sleep, a low-power enable bit chooses between counting on and freezing.

Register field positions: key bits 15:0 at address 0. Control at address 1: early threshold in bits 15:0, early-interrupt enable in bit 16, interrupt clear in bit 17 (write 1; reads as 0), low-power enable in bit 24. Reload at address 2: reload value in bits 15:0, prescaler in bits 23:16. Window bits 15:0 at address 3. The block runs on a single clock.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the outputs are low and the registers read as follows: key 0x0000_0000, control 0x0100_0000, reload 0x0063_0FFF, window 0x0000_FFFF.
- R2: Writes to addresses 1 to 3 take effect only while the key register holds 0x6969. Writing any other key value locks them again, and a locked write changes no register and no output.
- R3: Writing 0x3C3C to the key register starts the watchdog and loads the counter with RELOAD. No later write stops it.
- R4: After start, the prescaler field and the window register keep their values even while unlocked, and RELOAD remains writable.
- R5: With counting enabled, the counter decrements once every P counting cycles, where P is the prescaler value and a value of 0 acts as 1. The reset request rises on the clock edge that follows the counter reaching zero, which is RELOAD×P+1 edges after the starting write.
- R6: Writing 0x5A5A while running, with the counter at or below WINDOW, reloads the counter and restarts the prescaler phase.
- R7: Writing 0x5A5A while running, with the counter above WINDOW, raises the reset request on that edge. With WINDOW at 0xFFFF no feed is ever too early.
- R8: Once high, the reset request stays high until rst_n.
- R9: While dbg_halt is high or cpu_active is low, the counter and the prescaler hold their state.
- R10: While sleep is high, low-power enable = 1 keeps counting and low-power enable = 0 freezes the counter.
- R11: With the early enable bit set, early_irq rises on the edge where a decrement brings the counter to EICNT−1. It stays high until an unlocked control write with bit 17 set.
- R12: wake_req equals early_irq while sleep is high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| dbg_halt | input | 1 | Some CPU is halted for debug |
| cpu_active | input | 1 | At least one CPU is active |
| sleep | input | 1 | System is in sleep |
| early_irq | output | 1 | Pending early-warning interrupt |
| wake_req | output | 1 | Wakeup request during sleep |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench sweeps prescaler values 0 to 3 against several small reload values and measures the exact edge on which the reset request rises. An off-by-one in the prescaler wrap, or treating 0 as a divide-by-256, shows up as a wrong cycle count. It feeds on both sides of a small window: a design that compared with the wrong sense would reset on the good feed or miss the early one. It also tries to change the window and the prescaler after start, tries a clear while locked, and holds debug, inactive and frozen-sleep phases. A leaking pause or lock shortens the measured timeout or leaves a register changed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    A_KEY    = 2'd0,
    A_CTRL   = 2'd1,
    A_RELOAD = 2'd2,
    A_WIN    = 2'd3
  } wdt_addr_e;

  localparam logic [15:0] KEY_UNLOCK = 16'h6969;
  localparam logic [15:0] KEY_FEED   = 16'h5A5A;
  localparam logic [15:0] KEY_START  = 16'h3C3C;

  // control field positions decoded by software
  localparam int B_EIE  = 16;
  localparam int B_EIC  = 17;
  localparam int B_LPEN = 24;
  localparam int B_PRE  = 16;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PRE_RST = 8'h63,
  parameter logic [CNT_W-1:0] RLD_RST = 16'h0FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             enabled,
  output logic             start_pulse,
  output logic             feed_pulse,
  output logic             irq_clr,
  output logic             eie,
  output logic             lpen,
  output logic [CNT_W-1:0] eicnt,
  output logic [CNT_W-1:0] reload,
  output logic [PRE_W-1:0] presc,
  output logic [CNT_W-1:0] window
);
  logic [15:0] key_q;
  logic        key_wr, unlocked, cfg_wr;
  logic        wr_unused;

  assign wr_unused   = &{1'b0, wr_data[31:25]};
  assign key_wr      = wr_en && (wr_addr == A_KEY);
  assign unlocked    = (key_q == KEY_UNLOCK);
  assign cfg_wr      = wr_en && unlocked && (wr_addr != A_KEY);
  assign start_pulse = key_wr && (wr_data[15:0] == KEY_START) && !enabled;
  assign feed_pulse  = key_wr && (wr_data[15:0] == KEY_FEED) && enabled;
  assign irq_clr     = cfg_wr && (wr_addr == A_CTRL) && wr_data[B_EIC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      enabled <= 1'b0;
      eie     <= 1'b0;
      lpen    <= 1'b1;
      eicnt   <= '0;
      reload  <= RLD_RST;
      presc   <= PRE_RST;
      window  <= '1;
    end else begin
      if (key_wr) key_q <= wr_data[15:0];
      if (start_pulse) enabled <= 1'b1;
      if (cfg_wr) begin
        case (wr_addr)
          A_CTRL: begin
            eicnt <= wr_data[CNT_W-1:0];
            eie   <= wr_data[B_EIE];
            lpen  <= wr_data[B_LPEN];
          end
          A_RELOAD: begin
            reload <= wr_data[CNT_W-1:0];
            if (!enabled) presc <= wr_data[B_PRE +: PRE_W];
          end
          A_WIN: if (!enabled) window <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_KEY:    rd_data[15:0] = key_q;
      A_CTRL: begin
        rd_data[CNT_W-1:0] = eicnt;
        rd_data[B_EIE]     = eie;
        rd_data[B_LPEN]    = lpen;
      end
      A_RELOAD: begin
        rd_data[CNT_W-1:0]     = reload;
        rd_data[B_PRE +: PRE_W] = presc;
      end
      default:  rd_data[CNT_W-1:0] = window;
    endcase
  end

  assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |=> enabled);
  assert_window_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |=> $stable(window));
  assert_presc_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |=> $stable(presc));
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(eicnt) && $stable(reload) && $stable(eie) && $stable(lpen)));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pc_q;
  logic             last;

  assign last = (div <= PRE_W'(1)) || (pc_q == div - 1'b1);
  assign tick = run && last && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (restart) pc_q <= '0;
    else if (run)     pc_q <= last ? '0 : pc_q + 1'b1;
  end

  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div > PRE_W'(1)) |-> (pc_q < div));
  assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pc_q));
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             start,
  input  logic             feed_req,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] window,
  input  logic             eie,
  input  logic [CNT_W-1:0] eicnt,
  input  logic             irq_clr,
  output logic             irq_pend,
  output logic             rst_flag,
  output logic             load
);
  logic [CNT_W-1:0] cnt_q;
  logic             bad_feed, timeout, hit;

  assign bad_feed = feed_req && (cnt_q > window);
  assign load     = start || (feed_req && !bad_feed);
  assign timeout  = enabled && (cnt_q == '0) && !load;
  assign hit      = eie && tick && !load && (cnt_q != '0) &&
                    (eicnt != '0) && (cnt_q == eicnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rst_flag <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (load)                      cnt_q <= reload;
      else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      if (bad_feed || timeout)       rst_flag <= 1'b1;
      if (hit)                       irq_pend <= 1'b1;
      else if (irq_clr)              irq_pend <= 1'b0;
    end
  end

  assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag |=> rst_flag);
  assert_hold_paused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
  assert_early_point_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> (cnt_q == CNT_W'($past(eicnt) - 1'b1)));
  assert_early_feed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_feed |=> rst_flag);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PRE_RST = 8'h63,
  parameter logic [CNT_W-1:0] RLD_RST = 16'h0FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        dbg_halt,
  input  logic        cpu_active,
  input  logic        sleep,
  output logic        early_irq,
  output logic        wake_req,
  output logic        rst_req
);
  logic             enabled, start_pulse, feed_pulse, irq_clr, eie, lpen;
  logic [CNT_W-1:0] eicnt, reload, window;
  logic [PRE_W-1:0] presc;
  logic             run, tick, load;

  assign run      = enabled && cpu_active && !dbg_halt && !(sleep && !lpen);
  assign wake_req = early_irq && sleep;

  wdt_cfg #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST), .RLD_RST(RLD_RST)) u_cfg (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .enabled, .start_pulse, .feed_pulse, .irq_clr, .eie, .lpen,
    .eicnt, .reload, .presc, .window
  );

  wdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk, .rst_n, .restart(load), .run, .div(presc), .tick
  );

  wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .enabled, .start(start_pulse), .feed_req(feed_pulse),
    .run, .tick, .reload, .window, .eie, .eicnt, .irq_clr,
    .irq_pend(early_irq), .rst_flag(rst_req), .load
  );

  assert_wake_sleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (sleep && early_irq));
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dbg_halt = 1'b0, cpu_active = 1'b1, sleep = 1'b0;
  logic        early_irq, wake_req, rst_req;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  keyed_wdt u_dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .dbg_halt, .cpu_active, .sleep, .early_irq, .wake_req, .rst_req
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; dbg_halt = 1'b0; cpu_active = 1'b1; sleep = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // negedges after the current one until rst_req is seen high
  task automatic edges_to_reset(output int n);
    n = 0;
    while (!rst_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic setup(input logic [7:0] p, input logic [15:0] r);
    do_reset();
    wr(2'd0, 32'h6969);
    wr(2'd2, {8'h00, p, r});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    int rl[4] = '{1, 2, 3, 5};

    // R1 reset state
    do_reset();
    rd(2'd0, v); chk("R1 key", v, 32'h0);
    rd(2'd1, v); chk("R1 ctrl", v, 32'h0100_0000);
    rd(2'd2, v); chk("R1 reload", v, 32'h0063_0FFF);
    rd(2'd3, v); chk("R1 window", v, 32'h0000_FFFF);
    chk("R1 outputs", {29'd0, early_irq, wake_req, rst_req}, 32'h0);

    // R2 lock
    wr(2'd1, 32'h0001_0005);
    rd(2'd1, v); chk("R2 locked ctrl", v, 32'h0100_0000);
    wr(2'd0, 32'h6969);
    wr(2'd3, 32'h1234);
    rd(2'd3, v); chk("R2 unlocked window", v, 32'h1234);
    wr(2'd0, 32'h5A5A);
    wr(2'd3, 32'h0055);
    rd(2'd3, v); chk("R2 relocked window", v, 32'h1234);
    rd(2'd0, v); chk("R2 key readback", v, 32'h5A5A);

    // R5 sweep prescaler x reload; R3 start
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 4; i++) begin
        setup(p[7:0], rl[i][15:0]);
        wr(2'd0, 32'h3C3C);
        edges_to_reset(n);
        chk($sformatf("R5 R3 timeout p=%0d r=%0d", p, rl[i]), n,
            rl[i] * ((p == 0) ? 1 : p) + 1);
      end
    end

    // R4 frozen prescaler/window after start
    setup(8'h02, 16'h0008);
    wr(2'd3, 32'h00FF);
    wr(2'd0, 32'h3C3C);
    wr(2'd0, 32'h6969);
    wr(2'd2, 32'h0005_0020);
    wr(2'd3, 32'h0011);
    rd(2'd2, v); chk("R4 reload after start", v, 32'h0002_0020);
    rd(2'd3, v); chk("R4 window after start", v, 32'h00FF);

    // R6 good feed with open window
    setup(8'h01, 16'd10);
    wr(2'd0, 32'h3C3C);
    repeat (6) @(negedge clk);
    wr(2'd0, 32'h5A5A);
    chk("R6 no reset after feed", {31'd0, rst_req}, 32'h0);
    edges_to_reset(n); chk("R6 timeout after feed", n, 11);

    // R7 early feed, then R8 sticky
    setup(8'h01, 16'd10);
    wr(2'd3, 32'h3);
    wr(2'd0, 32'h3C3C);
    wr(2'd0, 32'h5A5A);
    chk("R7 early feed resets", {31'd0, rst_req}, 32'h1);
    repeat (5) @(negedge clk);
    wr(2'd0, 32'h5A5A);
    wr(2'd0, 32'h6969);
    wr(2'd2, 32'h0001_0100);
    chk("R8 reset sticky", {31'd0, rst_req}, 32'h1);

    // R7 feed inside window
    setup(8'h01, 16'd10);
    wr(2'd3, 32'h3);
    wr(2'd0, 32'h3C3C);
    repeat (7) @(negedge clk);
    wr(2'd0, 32'h5A5A);
    chk("R7 in-window feed accepted", {31'd0, rst_req}, 32'h0);
    edges_to_reset(n); chk("R7 timeout after in-window feed", n, 11);

    // R9 debug halt and inactive CPU
    setup(8'h01, 16'd5);
    dbg_halt = 1'b1;
    wr(2'd0, 32'h3C3C);
    repeat (20) @(negedge clk);
    chk("R9 held in debug", {31'd0, rst_req}, 32'h0);
    dbg_halt = 1'b0;
    edges_to_reset(n); chk("R9 resume after debug", n, 6);

    setup(8'h02, 16'd3);
    cpu_active = 1'b0;
    wr(2'd0, 32'h3C3C);
    repeat (20) @(negedge clk);
    chk("R9 held while inactive", {31'd0, rst_req}, 32'h0);
    cpu_active = 1'b1;
    edges_to_reset(n); chk("R9 resume after inactive", n, 7);

    // R10 sleep behaviour
    setup(8'h01, 16'd5);
    sleep = 1'b1;
    wr(2'd0, 32'h3C3C);
    edges_to_reset(n); chk("R10 counts in sleep lpen=1", n, 6);

    setup(8'h01, 16'd5);
    wr(2'd1, 32'h0000_0000);
    sleep = 1'b1;
    wr(2'd0, 32'h3C3C);
    repeat (30) @(negedge clk);
    chk("R10 frozen in sleep lpen=0", {31'd0, rst_req}, 32'h0);
    sleep = 1'b0;
    edges_to_reset(n); chk("R10 resume after sleep", n, 6);

    // R11 early interrupt, R12 wakeup
    setup(8'h01, 16'd10);
    wr(2'd1, 32'h0101_0004);
    sleep = 1'b1;
    wr(2'd0, 32'h3C3C);
    repeat (6) @(negedge clk);
    chk("R11 irq not yet", {31'd0, early_irq}, 32'h0);
    @(negedge clk);
    chk("R11 irq at EICNT-1", {31'd0, early_irq}, 32'h1);
    chk("R12 wake in sleep", {31'd0, wake_req}, 32'h1);
    sleep = 1'b0; #1;
    chk("R12 no wake awake", {31'd0, wake_req}, 32'h0);
    wr(2'd1, 32'h0103_0004);
    chk("R11 R2 locked clear ignored", {31'd0, early_irq}, 32'h1);
    wr(2'd0, 32'h6969);
    wr(2'd1, 32'h0103_0004);
    chk("R11 cleared", {31'd0, early_irq}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule